// File: doc/BRIEF.md
# PWM Fault Break Output Controller

This block sits between the complementary output pair of a PWM timer channel (a main output and its complement) and the pads. When a fault arrives it forces the pair into a safe state. Several fault sources feed it: two filtered application inputs, such as a fault pin and a comparator, and two raw system inputs, such as a clock-failure or memory-parity flag. Each source has its own enable and polarity. The qualified sources are ORed into one break line. A global enable gates that line and a global polarity selects its sense. An asserted break line clears the main output enable (MOE) at once, without waiting for a clock edge. MOE stays cleared until software sets it again.

While MOE is low, the pads are either released (output enables low) or driven by the block. When driven, both outputs sit at the inactive level for a programmable deadtime and then take programmed idle levels. The idle levels are interlocked so the two outputs are never active together. Software reaches the block through a simple write port and a combinational read port. There are four 16-bit registers:

- address 0, control and status
- address 1, source enables and polarities
- address 2, deadtime and filter length
- address 3, sticky source flags

Top module: `pwm_break_ctrl`

## Requirements
- R1: After reset, MOE is 0, the break line is disabled, both output enables are low with both outputs 0, and every register reads 0.
- R2: A break occurs only while the effective enable bit (address 0 bit 0) is 1. With the effective polarity bit (address 0 bit 1) at 1, the merged line breaks when any qualified source reports. At 0, it breaks when no qualified source reports.
- R3: A write to address 0 bits 0 and 1 takes effect one clock after the write edge. A read in the cycle right after the write returns the old values.
- R4: An asserted break clears MOE combinationally, before the next clock edge. MOE then stays 0 after the fault goes away, until software writes 1 to address 0 bit 2. A write of 1 made while the break is still asserted leaves MOE at 0.
- R5: The MOE value read at address 0 bit 2 passes through a two-stage synchronizer. After a write that sets MOE, reads in the first two cycles return 0 and the third returns 1, while the pads follow MOE at once.
- R6: Source i qualifies when enable bit i (address 1 bit i) is 1 and its level XOR polarity bit i (address 1 bit 8+i) is 1. A disabled source never causes a break.
- R7: Sources 0 and 1 go through a digital filter of length N = field + 1 (address 2 bits 10:8, N from 1 to 8). A level change is reported only after N consecutive equal samples, which takes N+1 clocks from the input change. Shorter pulses are ignored.
- R8: While MOE is 1, the outputs follow the PWM inputs with both output enables high. If both PWM inputs are 1, both outputs are 0. The two outputs are never 1 together.
- R9: While MOE is 0 and the off-state bit (address 0 bit 3) is 0, both output enables are low and both outputs are 0.
- R10: While MOE is 0 and the off-state bit is 1, both enables are high. Both outputs are 0 until D clocks have passed, where D is the deadtime (address 2 bits 7:0). After that they take the idle levels (address 0 bit 4 for the main output, bit 5 for the complement). If both idle bits are 1, both outputs are 0.
- R11: Flag bit i (address 3) is set at a clock edge where the break is asserted and source i qualifies. It stays set until a write with bit i at 1 to address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_oc | input | 1 | Main PWM output from the timer |
| pwm_ocn | input | 1 | Complementary PWM output from the timer |
| fault_in | input | NSRC | Fault source levels; 0..NFILT-1 are filtered, the rest are raw |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Register write address |
| reg_wdata | input | 16 | Register write data |
| reg_raddr | input | 2 | Register read address |
| reg_rdata | output | 16 | Register read data, combinational |
| oc_out | output | 1 | Main output to the pad |
| ocn_out | output | 1 | Complementary output to the pad |
| oc_oe | output | 1 | Pad drive enable for the main output |
| ocn_oe | output | 1 | Pad drive enable for the complementary output |

## Verification
The bench raises a raw fault between clock edges and checks the output enable a nanosecond later. A design that cleared MOE only on a clock edge would still be driving the pads at that point. Readback is checked cycle by cycle after MOE and polarity writes. A missing synchronizer would return 1 too early, and a missing polarity delay would break one cycle too soon. A 2-cycle pulse is applied against a 3-sample filter and must leave the outputs untouched. A held fault must break on exactly the fourth clock, so an off-by-one filter shows up. The deadtime is sampled one clock before and at its end. The both-active cases on the PWM inputs and on the idle levels catch a missing interlock.

// File: rtl/brk_pkg.sv
// Shared constants and helpers for the PWM fault break controller.
// Assumes a 2-bit register address and 16-bit register data.
package brk_pkg;
    localparam int REG_AW = 2;
    localparam int REG_DW = 16;

    localparam logic [REG_AW-1:0] A_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] A_SRC  = 2'd1;
    localparam logic [REG_AW-1:0] A_TIME = 2'd2;
    localparam logic [REG_AW-1:0] A_FLAG = 2'd3;

    localparam int B_EN     = 0;
    localparam int B_POL    = 1;
    localparam int B_MOE    = 2;
    localparam int B_OFF    = 3;
    localparam int B_IDLE_P = 4;
    localparam int B_IDLE_N = 5;

    localparam int SRC_POL_LSB = 8;
    localparam int FLEN_LSB    = 8;

    typedef struct packed {
        logic off_sel;
        logic idle_p;
        logic idle_n;
    } outcfg_t;

    // Drops both lines to inactive when both request the active level.
    function automatic logic [1:0] interlock(input logic p, input logic n);
        return {p & ~n, n & ~p};
    endfunction
endpackage

// File: rtl/brk_filter.sv
// Majority-free digital filter: the output follows the input only after
// the last N samples all agree, N = len_sel + 1.
// Assumes MAXLEN >= 2 and len_sel < MAXLEN.
module brk_filter #(
    parameter int MAXLEN = 8,
    localparam int LW = $clog2(MAXLEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] len_sel,
    input  logic          din,
    output logic          dout
);
    logic [MAXLEN-1:0] hist;
    logic [MAXLEN-1:0] mask;

    // Select the newest N sample positions.
    always_comb begin
        for (int k = 0; k < MAXLEN; k++) begin
            mask[k] = (k <= int'(len_sel));
        end
    end

    // Shift samples in and update the output on full agreement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
            dout <= 1'b0;
        end else begin
            hist <= {hist[MAXLEN-2:0], din};
            if ((hist & mask) == mask) begin
                dout <= 1'b1;
            end else if ((hist & mask) == '0) begin
                dout <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/brk_regs.sv
// Register file of the break controller. It holds the delayed enable and
// polarity, the output configuration, source setup, timing fields, sticky
// flags and the MOE readback synchronizer.
// Assumes NSRC <= 8 and DT_W <= 8 so that fields fit in 16-bit words.
module brk_regs
    import brk_pkg::*;
#(
    parameter int NSRC = 4,
    parameter int DT_W = 8,
    parameter int LW   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [REG_DW-1:0] wdata,
    input  logic [REG_AW-1:0] raddr,
    output logic [REG_DW-1:0] rdata,
    input  logic              moe,
    input  logic              brk_now,
    input  logic [NSRC-1:0]   src_hit,
    output logic              en_eff,
    output logic              pol_eff,
    output logic              moe_rd,
    output outcfg_t           ocfg,
    output logic [NSRC-1:0]   src_en,
    output logic [NSRC-1:0]   src_pol,
    output logic [DT_W-1:0]   dt_val,
    output logic [LW-1:0]     flen
);
    logic            en_sh;
    logic            pol_sh;
    logic [1:0]      moe_sy;
    logic [NSRC-1:0] flags;
    logic [NSRC-1:0] clr;

    // Capture software writes into configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_sh   <= 1'b0;
            pol_sh  <= 1'b0;
            ocfg    <= '0;
            src_en  <= '0;
            src_pol <= '0;
            dt_val  <= '0;
            flen    <= '0;
        end else if (we) begin
            case (waddr)
                A_CTRL: begin
                    en_sh  <= wdata[B_EN];
                    pol_sh <= wdata[B_POL];
                    ocfg   <= '{off_sel: wdata[B_OFF], idle_p: wdata[B_IDLE_P],
                                idle_n: wdata[B_IDLE_N]};
                end
                A_SRC: begin
                    src_en  <= wdata[NSRC-1:0];
                    src_pol <= wdata[SRC_POL_LSB +: NSRC];
                end
                A_TIME: begin
                    dt_val <= wdata[DT_W-1:0];
                    flen   <= wdata[FLEN_LSB +: LW];
                end
                default: ;
            endcase
        end
    end

    // Apply enable and polarity one clock after they are written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_eff  <= 1'b0;
            pol_eff <= 1'b0;
        end else begin
            en_eff  <= en_sh;
            pol_eff <= pol_sh;
        end
    end

    // Resynchronize the asynchronous MOE for software readback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            moe_sy <= '0;
        end else begin
            moe_sy <= {moe_sy[0], moe};
        end
    end
    assign moe_rd = moe_sy[1];

    // Decode write-one-to-clear strobes for the flags.
    always_comb begin
        clr = '0;
        if (we && waddr == A_FLAG) begin
            clr = wdata[NSRC-1:0];
        end
    end

    // Record which qualified source was present during a break.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr) | (src_hit & {NSRC{brk_now}});
        end
    end

    // Assemble read data for the addressed register.
    always_comb begin
        rdata = '0;
        case (raddr)
            A_CTRL: begin
                rdata[B_EN]     = en_eff;
                rdata[B_POL]    = pol_eff;
                rdata[B_MOE]    = moe_rd;
                rdata[B_OFF]    = ocfg.off_sel;
                rdata[B_IDLE_P] = ocfg.idle_p;
                rdata[B_IDLE_N] = ocfg.idle_n;
            end
            A_SRC: begin
                rdata[NSRC-1:0]            = src_en;
                rdata[SRC_POL_LSB +: NSRC] = src_pol;
            end
            A_TIME: begin
                rdata[DT_W-1:0]      = dt_val;
                rdata[FLEN_LSB +: LW] = flen;
            end
            default: rdata[NSRC-1:0] = flags;
        endcase
    end
endmodule

// File: rtl/brk_outstage.sv
// Output stage: passes the interlocked PWM pair while MOE is high. When MOE
// is low it either releases the pads, or drives them inactive for the
// deadtime and then drives the interlocked idle levels.
// Assumes active level is 1 on both outputs.
module brk_outstage
    import brk_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            moe,
    input  logic [DT_W-1:0] dt_val,
    input  outcfg_t         ocfg,
    input  logic            pwm_p,
    input  logic            pwm_n,
    output logic            out_p,
    output logic            out_n,
    output logic            oe_p,
    output logic            oe_n
);
    logic [DT_W-1:0] dt_cnt;
    logic            dt_done;

    // Count clocks since MOE dropped, saturating at the deadtime.
    always_ff @(posedge clk) begin
        if (!rst_n || moe) begin
            dt_cnt <= '0;
        end else if (dt_cnt != dt_val) begin
            dt_cnt <= dt_cnt + 1'b1;
        end
    end
    assign dt_done = (dt_cnt == dt_val);

    // Choose pad values and enables for the current state.
    always_comb begin
        if (moe) begin
            {out_p, out_n} = interlock(pwm_p, pwm_n);
            {oe_p, oe_n}   = 2'b11;
        end else if (!ocfg.off_sel) begin
            {out_p, out_n} = 2'b00;
            {oe_p, oe_n}   = 2'b00;
        end else if (!dt_done) begin
            {out_p, out_n} = 2'b00;
            {oe_p, oe_n}   = 2'b11;
        end else begin
            {out_p, out_n} = interlock(ocfg.idle_p, ocfg.idle_n);
            {oe_p, oe_n}   = 2'b11;
        end
    end
endmodule

// File: rtl/pwm_break_ctrl.sv
// Top of the PWM fault break controller. It qualifies each fault source,
// merges them into a break line, and clears MOE asynchronously on a break.
// The output stage shuts the complementary pair down safely.
// Assumes fault inputs NFILT..NSRC-1 are already glitch-free system flags.
module pwm_break_ctrl
    import brk_pkg::*;
#(
    parameter int NSRC   = 4,
    parameter int NFILT  = 2,
    parameter int FMAX   = 8,
    parameter int DT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm_oc,
    input  logic              pwm_ocn,
    input  logic [NSRC-1:0]   fault_in,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_waddr,
    input  logic [REG_DW-1:0] reg_wdata,
    input  logic [REG_AW-1:0] reg_raddr,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              oc_out,
    output logic              ocn_out,
    output logic              oc_oe,
    output logic              ocn_oe
);
    localparam int LW = $clog2(FMAX);

    logic [NSRC-1:0] lvl;
    logic [NSRC-1:0] src_en;
    logic [NSRC-1:0] src_pol;
    logic [NSRC-1:0] src_hit;
    logic [DT_W-1:0] dt_val;
    logic [LW-1:0]   flen;
    logic            en_eff;
    logic            pol_eff;
    logic            moe_rd;
    logic            merged;
    logic            brk_now;
    logic            moe_q;
    outcfg_t         ocfg;

    // Filter the application sources, pass system sources straight through.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (i < NFILT) begin : g_filt
            brk_filter #(.MAXLEN(FMAX)) u_filt (
                .clk     (clk),
                .rst_n   (rst_n),
                .len_sel (flen),
                .din     (fault_in[i]),
                .dout    (lvl[i])
            );
        end else begin : g_raw
            assign lvl[i] = fault_in[i];
        end
    end

    // Qualify sources and form the global break line.
    always_comb begin
        src_hit = src_en & (lvl ^ src_pol);
        merged  = |src_hit;
        brk_now = en_eff & (pol_eff ? merged : ~merged);
    end

    // MOE: set by software, cleared at once by a break.
    always_ff @(posedge clk or posedge brk_now) begin
        if (brk_now) begin
            moe_q <= 1'b0;
        end else if (!rst_n) begin
            moe_q <= 1'b0;
        end else if (reg_we && reg_waddr == A_CTRL) begin
            moe_q <= reg_wdata[B_MOE];
        end
    end

    brk_regs #(.NSRC(NSRC), .DT_W(DT_W), .LW(LW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .waddr   (reg_waddr),
        .wdata   (reg_wdata),
        .raddr   (reg_raddr),
        .rdata   (reg_rdata),
        .moe     (moe_q),
        .brk_now (brk_now),
        .src_hit (src_hit),
        .en_eff  (en_eff),
        .pol_eff (pol_eff),
        .moe_rd  (moe_rd),
        .ocfg    (ocfg),
        .src_en  (src_en),
        .src_pol (src_pol),
        .dt_val  (dt_val),
        .flen    (flen)
    );

    brk_outstage #(.DT_W(DT_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .moe    (moe_q),
        .dt_val (dt_val),
        .ocfg   (ocfg),
        .pwm_p  (pwm_oc),
        .pwm_n  (pwm_ocn),
        .out_p  (oc_out),
        .out_n  (ocn_out),
        .oe_p   (oc_oe),
        .oe_n   (ocn_oe)
    );
endmodule

// File: rtl/pwm_break_chk.sv
// Property checker for the break controller, attached by bind.
// Assumes reset is held low for at least two clocks at start-up.
module pwm_break_chk (
    input logic clk,
    input logic rst_n,
    input logic oc_out,
    input logic ocn_out,
    input logic oc_oe,
    input logic ocn_oe,
    input logic moe,
    input logic moe_rd,
    input logic brk_now,
    input logic off_sel
);
    a_r8_never_both_active: assert property (@(posedge clk) disable iff (!rst_n)
        !(oc_out && ocn_out));

    a_r4_break_holds_moe_low: assert property (@(posedge clk) disable iff (!rst_n)
        brk_now |-> !moe);

    a_r5_readback_lags: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(moe) |-> !moe_rd);

    a_r9_pads_released: assert property (@(posedge clk) disable iff (!rst_n)
        (!moe && !off_sel) |-> (!oc_oe && !ocn_oe));

    a_r10_idle_interlock: assert property (@(posedge clk) disable iff (!rst_n)
        (!moe && off_sel) |-> (oc_oe && ocn_oe));
endmodule

bind pwm_break_ctrl pwm_break_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .oc_out  (oc_out),
    .ocn_out (ocn_out),
    .oc_oe   (oc_oe),
    .ocn_oe  (ocn_oe),
    .moe     (moe_q),
    .moe_rd  (moe_rd),
    .brk_now (brk_now),
    .off_sel (ocfg.off_sel)
);

// File: tb/pwm_break_ctrl_tb_top.sv
// Self-checking bench for pwm_break_ctrl: a vector table for output mapping,
// then directed tests for reset, timing and corner cases.
module pwm_break_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwm_oc = 1'b0;
    logic        pwm_ocn = 1'b0;
    logic [3:0]  fault_in = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_waddr = '0;
    logic [15:0] reg_wdata = '0;
    logic [1:0]  reg_raddr = '0;
    logic [15:0] reg_rdata;
    logic        oc_out, ocn_out, oc_oe, ocn_oe;

    int nchk = 0;
    int nfail = 0;

    // {mode, a, b, exp_p, exp_n}; mode 0 = PWM pass (R8), 1 = idle levels (R10)
    localparam logic [4:0] VEC [8] = '{
        5'b0_00_00, 5'b0_10_10, 5'b0_01_01, 5'b0_11_00,
        5'b1_00_00, 5'b1_10_10, 5'b1_01_01, 5'b1_11_00
    };

    always #4 clk = ~clk;

    pwm_break_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_oc    (pwm_oc),
        .pwm_ocn   (pwm_ocn),
        .fault_in  (fault_in),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata),
        .oc_out    (oc_out),
        .ocn_out   (ocn_out),
        .oc_oe     (oc_oe),
        .ocn_oe    (ocn_oe)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_waddr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [1:0] a,
                         input logic [15:0] m, input logic [15:0] exp);
        reg_raddr = a;
        #1;
        check(req, reg_rdata & m, exp);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 oe", {14'd0, oc_oe, ocn_oe}, 16'h0);
        check("R1 out", {14'd0, oc_out, ocn_out}, 16'h0);
        rdchk("R1 ctrl", 2'd0, 16'hFFFF, 16'h0);
        rdchk("R1 time", 2'd2, 16'hFFFF, 16'h0);
        rdchk("R1 flag", 2'd3, 16'hFFFF, 16'h0);

        wr(2'd1, 16'h000F);
        wr(2'd2, 16'h0000);
        wr(2'd0, 16'h000F);
        // R3: enable/polarity read old value just after write; R5: MOE lag
        rdchk("R3 old", 2'd0, 16'h0003, 16'h0000);
        rdchk("R5 lag1", 2'd0, 16'h0004, 16'h0000);
        check("R5 pad live", {15'd0, oc_oe}, 16'h1);
        @(negedge clk);
        rdchk("R3 new", 2'd0, 16'h0003, 16'h0003);
        rdchk("R5 lag2", 2'd0, 16'h0004, 16'h0000);
        @(negedge clk);
        rdchk("R5 set", 2'd0, 16'h0004, 16'h0004);

        // Vector table: R8 pass-through and R10 idle interlock
        for (int i = 0; i < 8; i++) begin
            if (VEC[i][4]) begin
                wr(2'd0, 16'h000B | (16'(VEC[i][3]) << 4) | (16'(VEC[i][2]) << 5));
            end else begin
                pwm_oc = VEC[i][3];
                pwm_ocn = VEC[i][2];
                #1;
            end
            check(VEC[i][4] ? "R10 idle" : "R8 pass", {14'd0, oc_out, ocn_out},
                  {14'd0, VEC[i][1], VEC[i][0]});
        end
        pwm_oc = 1'b0;
        pwm_ocn = 1'b0;

        // R4/R9: asynchronous clear with pads released
        wr(2'd0, 16'h0007);
        pwm_oc = 1'b1;
        #1;
        check("R8 on", {15'd0, oc_out}, 16'h1);
        fault_in[2] = 1'b1;
        #1;
        check("R4 async", {14'd0, oc_oe, ocn_oe}, 16'h0);
        check("R9 out", {14'd0, oc_out, ocn_out}, 16'h0);
        @(negedge clk);
        rdchk("R11 flag", 2'd3, 16'h000F, 16'h0004);
        wr(2'd0, 16'h0007);
        check("R4 blocked", {15'd0, oc_oe}, 16'h0);
        fault_in[2] = 1'b0;
        repeat (3) @(negedge clk);
        check("R4 stays", {15'd0, oc_oe}, 16'h0);
        rdchk("R11 sticky", 2'd3, 16'h000F, 16'h0004);
        wr(2'd3, 16'h0004);
        rdchk("R11 clear", 2'd3, 16'h000F, 16'h0000);
        wr(2'd0, 16'h0007);
        check("R4 reset", {15'd0, oc_oe}, 16'h1);
        pwm_oc = 1'b0;

        // R6: disabled source ignored, then active-low source
        wr(2'd1, 16'h0007);
        fault_in[3] = 1'b1;
        @(negedge clk);
        check("R6 disabled", {15'd0, oc_oe}, 16'h1);
        rdchk("R6 noflag", 2'd3, 16'h000F, 16'h0000);
        wr(2'd1, 16'h080F);
        check("R6 pol high", {15'd0, oc_oe}, 16'h1);
        fault_in[3] = 1'b0;
        #1;
        check("R6 pol low", {15'd0, oc_oe}, 16'h0);
        @(negedge clk);
        rdchk("R11 src3", 2'd3, 16'h000F, 16'h0008);
        wr(2'd1, 16'h000F);
        wr(2'd3, 16'h000F);
        wr(2'd0, 16'h0007);

        // R2/R3: global polarity low, applied one clock late
        wr(2'd0, 16'h0005);
        check("R3 pol delay", {15'd0, oc_oe}, 16'h1);
        @(negedge clk);
        check("R2 pol low", {15'd0, oc_oe}, 16'h0);
        fault_in[2] = 1'b1;
        wr(2'd0, 16'h0005);
        check("R2 pol low held", {15'd0, oc_oe}, 16'h1);
        @(negedge clk);
        fault_in[2] = 1'b0;
        #1;
        check("R2 pol low idle", {15'd0, oc_oe}, 16'h0);
        wr(2'd0, 16'h0007);
        wr(2'd0, 16'h0007);
        check("R2 restore", {15'd0, oc_oe}, 16'h1);

        // R2: break disabled
        wr(2'd0, 16'h0006);
        @(negedge clk);
        fault_in[2] = 1'b1;
        #1;
        check("R2 disabled", {15'd0, oc_oe}, 16'h1);
        @(negedge clk);
        rdchk("R2 noflag", 2'd3, 16'h000F, 16'h0000);
        fault_in[2] = 1'b0;
        wr(2'd0, 16'h0007);
        @(negedge clk);

        // R7: three-sample filter on source 0
        wr(2'd2, 16'h0200);
        fault_in[0] = 1'b1;
        repeat (2) @(negedge clk);
        fault_in[0] = 1'b0;
        repeat (4) @(negedge clk);
        check("R7 short pulse", {15'd0, oc_oe}, 16'h1);
        fault_in[0] = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 before", {15'd0, oc_oe}, 16'h1);
        @(negedge clk);
        check("R7 break", {15'd0, oc_oe}, 16'h0);
        @(negedge clk);
        rdchk("R11 src0", 2'd3, 16'h000F, 16'h0001);
        fault_in[0] = 1'b0;
        repeat (6) @(negedge clk);
        wr(2'd3, 16'h000F);
        wr(2'd0, 16'h0007);

        // R10: deadtime of 5 then idle levels
        wr(2'd2, 16'h0005);
        wr(2'd0, 16'h001F);
        pwm_ocn = 1'b1;
        #1;
        check("R8 ocn", {14'd0, oc_out, ocn_out}, 16'h1);
        fault_in[2] = 1'b1;
        #1;
        check("R10 dead out", {14'd0, oc_out, ocn_out}, 16'h0);
        check("R10 dead oe", {14'd0, oc_oe, ocn_oe}, 16'h3);
        repeat (4) @(negedge clk);
        check("R10 before end", {14'd0, oc_out, ocn_out}, 16'h0);
        @(negedge clk);
        check("R10 idle", {14'd0, oc_out, ocn_out}, 16'h2);
        fault_in[2] = 1'b0;
        pwm_ocn = 1'b0;
        @(negedge clk);

        finish_run();
    end
endmodule